// File: doc/BRIEF.md
# PCM Serial Transmit Port

This block sends one 8-bit companded sample per frame on a serial data line. The line can be switched to high impedance, so it is modelled as a data bit plus a separate drive enable. A frame-sync input marks each frame and a bit-clock input sets the shift timing. Both are sampled by the system clock, so edges on them are seen as events in that clock's domain. An active-low slot indicator is low for the eight bit periods of the slot.

The width of the frame-sync pulse sets the frame format. A pulse one bit period wide selects short framing, and a pulse three or more bit periods wide selects long framing. The two formats use different rules for when the line is driven and when it is released. The detected format applies from the frame after the one that was measured.

Codes arrive on a valid/ready input and are kept in a holding register. A frame always sends the code that was held when the frame started, so the data runs one frame behind the producer. When no new code arrives, the held code is sent again. An A-law mode inverts the alternate (even) bits as the code is taken for sending.

Top module: `pcm_tx_port`

## Requirements
- R1: After reset, tx_data_en is 0, slot_n is 1, tx_data is 0 and short framing is selected.
- R2: Short framing. If frame_sync is high at a bit_clk falling edge, the next bit_clk rising edge enables the line and drives the code MSB. Each of the next seven rising edges drives the next lower bit.
- R3: Short framing. The line is released at the bit_clk falling edge that follows the eighth rising edge.
- R4: Long framing. The line is enabled at the later of two events: the frame_sync rising edge or a bit_clk rising edge. If frame_sync rises while bit_clk is low, nothing is driven until the next rising edge. The MSB is driven first.
- R5: Long framing. The line is released at the later of two events: the bit_clk falling edge after the eighth rising edge, or frame_sync going low.
- R6: Frame format detection counts the bit_clk falling edges seen while frame_sync is high. When frame_sync falls, a count of 1 selects short framing and a count of 3 or more selects long framing. A count of 2 leaves the format unchanged. The new format takes effect from the next frame.
- R7: slot_n is low from the cycle the line is enabled until the falling edge after the eighth rising edge. This does not depend on how long frame_sync stays high.
- R8: A frame sends the code held when the frame starts. If a code is accepted in the same cycle the frame starts, it is sent in the following frame.
- R9: If no code is accepted between two frames, the second frame sends the same code again.
- R10: When alaw_mode is 1 at frame start, the sent byte is the held code XOR 8'h55, so bits 6, 4, 2 and 0 are inverted (for example, 8'h80 is sent as 8'hD5). When alaw_mode is 0, the held code is sent unchanged (8'h80, 8'hFF and 8'h00 are sent as they are).
- R11: code_ready is always 1 and the input applies no back-pressure. Every cycle with code_valid high replaces the held code, so the last code accepted wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all inputs |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_clk | input | 1 | Transmit bit clock, sampled as a level |
| frame_sync | input | 1 | Transmit frame sync, sampled as a level |
| alaw_mode | input | 1 | 1 inverts the even code bits at frame start |
| code_data | input | 8 | Companded code to send in a later frame |
| code_valid | input | 1 | code_data is valid this cycle |
| code_ready | output | 1 | Always 1; the holding register accepts every cycle |
| tx_data | output | 1 | Serial data bit, MSB first; 0 while not enabled |
| tx_data_en | output | 1 | Drive enable for the serial line |
| slot_n | output | 1 | Active low for the eight-bit transmit slot |

## Verification
A new code can be accepted in the same cycle that a frame captures the held code. This is provoked by raising code_valid for exactly the system-clock cycle in which the bit_clk rising edge starts the frame, in both short and long framing. It is judged by the scoreboard: that frame must carry the previous code and the following frame must carry the new one. A second meeting point also gets a check: the end of the eighth bit and a frame_sync that is still high, where the drive enable must stay on after the slot indicator has returned high.

// File: rtl/pcmtx_pkg.sv
package pcmtx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARM   = 2'd1,
    ST_SHIFT = 2'd2,
    ST_TAIL  = 2'd3
  } tx_state_e;
endpackage

// File: rtl/pcmtx_sampler.sv
module pcmtx_sampler #(
  parameter int STAGES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= lvl;
  end

  assign lvl  = chain[STAGES-1];
  assign rise = lvl & ~prev;
  assign fall = ~lvl & prev;
endmodule

// File: rtl/pcmtx_fmt_detect.sv
module pcmtx_fmt_detect #(
  parameter int LONG_MIN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fs_lvl,
  input  logic fs_fall,
  input  logic bclk_fall,
  output logic is_long
);
  localparam int CW = $clog2(LONG_MIN + 1);
  localparam logic [CW-1:0] SAT = CW'(LONG_MIN);

  logic [CW-1:0] width_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      width_cnt <= '0;
      is_long   <= 1'b0;
    end else if (fs_fall) begin
      if (width_cnt >= SAT)              is_long <= 1'b1;
      else if (width_cnt == CW'(1))      is_long <= 1'b0;
      width_cnt <= '0;
    end else if (bclk_fall && fs_lvl && width_cnt < SAT) begin
      width_cnt <= width_cnt + CW'(1);
    end
  end

  // R6
  fmt_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(is_long) |-> $past(fs_fall));
endmodule

// File: rtl/pcmtx_slot_seq.sv
module pcmtx_slot_seq
  import pcmtx_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bclk_lvl,
  input  logic         bclk_rise,
  input  logic         bclk_fall,
  input  logic         fs_lvl,
  input  logic         fs_rise,
  input  logic         fmt_long,
  input  logic [W-1:0] load_word,
  output logic         frame_start,
  output logic         tx_bit,
  output logic         tx_en,
  output logic         slot_n
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST = CW'(W);

  tx_state_e     state;
  logic [W-1:0]  shreg;
  logic [CW-1:0] cnt;
  logic          en_q, slot_q, frm_long, arm_go;

  always_comb begin
    frame_start = ((state == ST_IDLE) && fmt_long && fs_rise && bclk_lvl) ||
                  ((state == ST_ARM) && bclk_rise);
    arm_go = (state == ST_IDLE) && !frame_start &&
             (fmt_long ? fs_rise : (bclk_fall && fs_lvl));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      shreg    <= '0;
      cnt      <= '0;
      en_q     <= 1'b0;
      slot_q   <= 1'b0;
      frm_long <= 1'b0;
    end else if (frame_start) begin
      if (state == ST_IDLE) frm_long <= fmt_long;
      shreg  <= load_word;
      cnt    <= CW'(1);
      en_q   <= 1'b1;
      slot_q <= 1'b1;
      state  <= ST_SHIFT;
    end else if (arm_go) begin
      state    <= ST_ARM;
      frm_long <= fmt_long;
    end else begin
      case (state)
        ST_SHIFT: begin
          if (bclk_rise && cnt < LAST) begin
            shreg <= {shreg[W-2:0], 1'b0};
            cnt   <= cnt + CW'(1);
          end else if (bclk_fall && cnt == LAST) begin
            slot_q <= 1'b0;
            if (!frm_long || !fs_lvl) begin
              en_q  <= 1'b0;
              state <= ST_IDLE;
            end else begin
              state <= ST_TAIL;
            end
          end
        end
        ST_TAIL: begin
          if (!fs_lvl) begin
            en_q  <= 1'b0;
            state <= ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  assign tx_en  = en_q;
  assign slot_n = ~slot_q;
  assign tx_bit = en_q ? shreg[W-1] : 1'b0;

  // R7
  slot_in_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_n |-> tx_en);

  // R2
  bit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

  // R3
  short_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slot_n) && !frm_long |-> !tx_en);

  // R5
  tail_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TAIL) && !fs_lvl |=> !tx_en);
endmodule

// File: rtl/pcm_tx_port.sv
module pcm_tx_port #(
  parameter int CODE_W      = 8,
  parameter int SYNC_STAGES = 1,
  parameter int LONG_MIN    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_clk,
  input  logic              frame_sync,
  input  logic              alaw_mode,
  input  logic [CODE_W-1:0] code_data,
  input  logic              code_valid,
  output logic              code_ready,
  output logic              tx_data,
  output logic              tx_data_en,
  output logic              slot_n
);
  logic bclk_lvl, bclk_rise, bclk_fall;
  logic fs_lvl, fs_rise, fs_fall;
  logic fmt_long, frame_start;
  logic [CODE_W-1:0] held_code, alaw_mask, load_word;

  generate
    for (genvar b = 0; b < CODE_W; b++) begin : g_mask
      assign alaw_mask[b] = (b % 2 == 0);
    end
  endgenerate

  pcmtx_sampler #(.STAGES(SYNC_STAGES)) u_bclk (
    .clk(clk), .rst_n(rst_n), .d(bit_clk),
    .lvl(bclk_lvl), .rise(bclk_rise), .fall(bclk_fall));

  pcmtx_sampler #(.STAGES(SYNC_STAGES)) u_fsync (
    .clk(clk), .rst_n(rst_n), .d(frame_sync),
    .lvl(fs_lvl), .rise(fs_rise), .fall(fs_fall));

  pcmtx_fmt_detect #(.LONG_MIN(LONG_MIN)) u_fmt (
    .clk(clk), .rst_n(rst_n), .fs_lvl(fs_lvl), .fs_fall(fs_fall),
    .bclk_fall(bclk_fall), .is_long(fmt_long));

  assign code_ready = 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n)          held_code <= '0;
    else if (code_valid) held_code <= code_data;
  end

  assign load_word = alaw_mode ? (held_code ^ alaw_mask) : held_code;

  pcmtx_slot_seq #(.W(CODE_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .bclk_lvl(bclk_lvl), .bclk_rise(bclk_rise), .bclk_fall(bclk_fall),
    .fs_lvl(fs_lvl), .fs_rise(fs_rise), .fmt_long(fmt_long),
    .load_word(load_word), .frame_start(frame_start),
    .tx_bit(tx_data), .tx_en(tx_data_en), .slot_n(slot_n));

  // R8
  start_needs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> bclk_rise || fs_rise);
endmodule

// File: tb/test_pcm_tx_port.sv
module test_pcm_tx_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_clk = 1'b0, frame_sync = 1'b0, alaw_mode = 1'b0;
  logic [7:0] code_data = '0;
  logic code_valid = 1'b0;
  logic code_ready, tx_data, tx_data_en, slot_n;

  int vecs = 0, errs = 0;
  logic [7:0] exp_q[$];
  logic [7:0] pend = 8'h00;
  logic hi_en, hi_slot, hi_d, lo_en;
  event hi_end;

  always #10 clk = ~clk;

  pcm_tx_port i_pcm_tx_port (
    .clk(clk), .rst_n(rst_n), .bit_clk(bit_clk), .frame_sync(frame_sync),
    .alaw_mode(alaw_mode), .code_data(code_data), .code_valid(code_valid),
    .code_ready(code_ready), .tx_data(tx_data), .tx_data_en(tx_data_en),
    .slot_n(slot_n));

  task automatic check(input string req, input int act, input int expv);
    vecs++;
    if (act != expv) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // one bit period: 4 system clocks high, 4 low; called at a negedge
  task automatic period(input bit fhi, input bit flo, input bit ld, input logic [7:0] ldv);
    bit_clk = 1'b1; frame_sync = fhi;
    if (ld) begin
      @(negedge clk); code_valid = 1'b1; code_data = ldv;
      @(negedge clk); code_valid = 1'b0;
      repeat (2) @(negedge clk);
    end else repeat (4) @(negedge clk);
    hi_en = tx_data_en; hi_slot = slot_n; hi_d = tx_data;
    -> hi_end;
    bit_clk = 1'b0; frame_sync = flo;
    repeat (4) @(negedge clk);
    lo_en = tx_data_en;
  endtask

  task automatic load(input logic [7:0] v);
    code_valid = 1'b1; code_data = v;
    @(negedge clk); code_valid = 1'b0; pend = v;
  endtask

  // L: frame-sync width in bit periods; mode: 0 unchecked, 1 short, 2 long
  task automatic frame(input int L, input bit early, input int mode,
                       input bit ld, input logic [7:0] ldv);
    int n = ((L > 8) ? L : 8) + 2;
    int ldat = (mode == 1) ? 1 : 0;
    exp_q.push_back(alaw_mode ? (pend ^ 8'h55) : pend);
    if (early) begin
      period(1'b0, 1'b1, 1'b0, 8'h00);
      if (mode == 2) begin
        check("R4 no drive before bit_clk rise (hi)", hi_en, 0);
        check("R4 no drive before bit_clk rise (lo)", lo_en, 0);
      end
    end
    for (int j = 0; j < n; j++) begin
      period(j < L, j < L, ld && (j == ldat), ldv);
      if (mode == 1) begin
        check($sformatf("R2 short enable period %0d", j), hi_en, int'(j >= 1 && j <= 8));
        check($sformatf("R3 short release period %0d", j), lo_en, int'(j >= 1 && j <= 7));
        check($sformatf("R7 short slot period %0d", j), hi_slot, int'(!(j >= 1 && j <= 8)));
      end else if (mode == 2) begin
        check($sformatf("R4 long enable period %0d", j), hi_en,
              int'(j <= ((L - 1 > 7) ? L - 1 : 7)));
        check($sformatf("R5 long release period %0d", j), lo_en,
              int'(j < 7 || (j <= L - 1)));
        check($sformatf("R7 long slot period %0d", j), hi_slot, int'(j > 7));
      end
    end
    if (ld) pend = ldv;
    period(1'b0, 1'b0, 1'b0, 8'h00);
  endtask

  // monitor: assembles each slot's bits and compares against the scoreboard
  initial begin
    logic [7:0] acc = '0;
    int nb = 0;
    forever begin
      @(hi_end);
      if (!hi_slot) begin
        acc = {acc[6:0], hi_d};
        nb++;
        if (nb == 8) begin
          nb = 0;
          if (exp_q.size() == 0) check("R8 unexpected slot", acc, 0);
          else check("R8 R10 sent byte", acc, exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check("R1 enable after reset", tx_data_en, 0);
    check("R1 slot after reset", slot_n, 1);
    check("R1 data after reset", tx_data, 0);
    check("R11 ready", code_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);

    load(8'hA3);
    frame(1, 1'b0, 1, 1'b0, 8'h00);          // R2 R3, sends A3
    frame(1, 1'b0, 1, 1'b0, 8'h00);          // R9 resend A3
    load(8'h11); load(8'h80);                // R11 last wins
    alaw_mode = 1'b1;
    frame(1, 1'b0, 1, 1'b0, 8'h00);          // R10 80 -> D5
    alaw_mode = 1'b0;
    frame(1, 1'b0, 1, 1'b0, 8'h00);          // R10 80 unchanged
    load(8'h00);
    frame(1, 1'b0, 1, 1'b0, 8'h00);
    load(8'hFF);
    frame(1, 1'b0, 1, 1'b1, 8'h6E);          // R8 same-cycle load, sends FF
    frame(1, 1'b0, 1, 1'b0, 8'h00);          // R8 now 6E
    load(8'h5C);
    frame(4, 1'b0, 0, 1'b0, 8'h00);          // R6 long pulse seen in short mode
    frame(4, 1'b0, 2, 1'b0, 8'h00);          // R4 R5 long
    frame(10, 1'b0, 2, 1'b1, 8'h39);         // R5 tail, R8 same-cycle load
    frame(5, 1'b1, 2, 1'b0, 8'h00);          // R4 fs rises with bit_clk low
    frame(2, 1'b0, 2, 1'b0, 8'h00);          // R6 width 2 keeps long
    frame(3, 1'b0, 2, 1'b0, 8'h00);          // R6 still long
    frame(1, 1'b0, 2, 1'b0, 8'h00);          // R6 width 1 measured under long
    frame(1, 1'b0, 1, 1'b0, 8'h00);          // R6 back to short
    repeat (4) period(1'b0, 1'b0, 1'b0, 8'h00);
    check("R8 scoreboard drained", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule